// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block is a host-addressed parallel I/O peripheral with three 8-bit ports, A, B and C. Port C splits into an upper and a lower nibble, so the ports form four direction groups: A, B, C-high and C-low. Each group is set as an input or an output by one control word. Output groups drive data held in write latches. Input groups are read live from the pins, with no latching and no handshake.

The host reaches the block through a chip select, read and write strobes, a 2-bit address and 8-bit write and read buses. Addresses 0, 1 and 2 select ports A, B and C. Address 3 selects the control register.

A control write does one of two things, chosen by bit 7:
- **Mode set.** It reprograms all four directions, clears every output latch and clears all interrupt-enable flags.
- **Bit set/reset.** It sets or clears one port C latch bit and the interrupt-enable flag of the same index, with no read-modify-write by the host.

The interrupt-enable flags drive nothing inside the block. They appear only on a status output.

The host bus is a plain register interface, not a stream. A write is always accepted in the cycle it is presented, and a read always returns data in the same cycle. There is no back-pressure in either direction.

Top module: `ppi_port`

## Requirements
- R1: After reset all four groups are inputs: every output-enable bit is 0, every output latch is 0 and every interrupt-enable flag is 0.
- R2: A control write (address 3) with bit 7 = 1 is a mode set. It sets the directions as follows, with 1 = input and 0 = output:
  - bit 4: port A
  - bit 3: port C upper nibble
  - bit 1: port B
  - bit 0: port C lower nibble

  Each output-enable bit is the inverse of its group's direction bit. Bits 6, 5 and 2 have no effect.
- R3: A mode-set write clears all three output latches and all eight interrupt-enable flags.
- R4: A port write takes effect at the rising clock edge where cs and wr are both 1. Address 0 loads latch A, address 1 loads latch B and address 2 loads latch C. The latch value appears on the port's output pins from the next cycle. With cs = 0, wr has no effect.
- R5: While cs and rd are both 1, a read of address 0, 1 or 2 returns data in the same cycle. For each group, an output group returns its latch contents and an input group returns its live input pins. Port C is selected nibble by nibble.
- R6: A read of address 3 returns 0. rdata is 0 whenever cs and rd are not both 1.
- R7: A control write with bit 7 = 0 is a bit set/reset. Bits 3..1 give the port C bit index and bit 0 gives the value (1 = set, 0 = clear). Only that one port C latch bit changes, and bits 6..4 have no effect.
- R8: A bit set/reset write also sets or clears the interrupt-enable flag with the same index, and leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, sampled at the clock edge |
| addr | input | 2 | 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C input pins |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, per nibble |
| int_en | output | 8 | Interrupt-enable flags, status only |

## Verification
The bench builds the block with its default 8-bit port width. That width gives a 3-bit bit-select field and 4-bit C nibbles. At this width the bench can sweep all 16 direction configurations and walk a bit set and a bit clear across all eight port C indices. With mixed directions the bench reads port C and checks that each nibble comes from its own source, latch or pins. Bench pin values differ from the latch values, so a read taken from the wrong source shows up in the returned data.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam logic [1:0] ADDR_A    = 2'd0;
  localparam logic [1:0] ADDR_B    = 2'd1;
  localparam logic [1:0] ADDR_C    = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // direction per group, 1 = input
  typedef struct packed {
    logic a;
    logic cu;
    logic b;
    logic cl;
  } dir_t;

  localparam dir_t DIR_ALL_IN = '{a: 1'b1, cu: 1'b1, b: 1'b1, cl: 1'b1};
endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SELW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_we,
  input  logic            bsr_we,
  input  dir_t            dir_d,
  input  logic [SELW-1:0] bsr_idx,
  input  logic            bsr_val,
  output dir_t            dir_q,
  output logic [DW-1:0]   int_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_ALL_IN;
      int_en <= '0;
    end else if (mode_we) begin
      dir_q  <= dir_d;
      int_en <= '0;
    end else if (bsr_we) begin
      int_en[bsr_idx] <= bsr_val;
    end
  end
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W    = 8,
  parameter int SELW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  logic [W-1:0]    d,
  input  logic            bit_we,
  input  logic [SELW-1:0] bit_idx,
  input  logic            bit_val,
  output logic [W-1:0]    q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (we)     q <= d;
    else if (bit_we) q[bit_idx] <= bit_val;
  end
endmodule

// File: rtl/ppi_rdmux.sv
module ppi_rdmux
  import ppi_pkg::*;
#(
  parameter int DW = 8,
  localparam int H = DW / 2
) (
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  dir_t          dir,
  input  logic [DW-1:0] la,
  input  logic [DW-1:0] lb,
  input  logic [DW-1:0] lc,
  input  logic [DW-1:0] pa,
  input  logic [DW-1:0] pb,
  input  logic [DW-1:0] pc,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] va, vb, vc;

  assign va = dir.a ? pa : la;
  assign vb = dir.b ? pb : lb;
  assign vc = {dir.cu ? pc[DW-1:H] : lc[DW-1:H],
               dir.cl ? pc[H-1:0]  : lc[H-1:0]};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_A:  rdata = va;
        ADDR_B:  rdata = vb;
        ADDR_C:  rdata = vc;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_port.sv
module ppi_port
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic [DW-1:0] int_en
);
  localparam int SELW  = $clog2(DW);
  localparam int H     = DW / 2;
  localparam int NPORT = 3;

  logic            wr_en, ctrl_we, mode_we, bsr_we;
  dir_t            dir_d, dir_q;
  logic [SELW-1:0] bsr_idx;
  logic            bsr_val;
  logic [DW-1:0]   lat [NPORT];
  logic            unused_ctrl_bits;

  assign wr_en   = cs & wr;
  assign ctrl_we = wr_en && (addr == ADDR_CTRL);
  assign mode_we = ctrl_we &  wdata[DW-1];
  assign bsr_we  = ctrl_we & ~wdata[DW-1];
  assign bsr_idx = wdata[SELW:1];
  assign bsr_val = wdata[0];
  assign dir_d   = '{a: wdata[4], cu: wdata[3], b: wdata[1], cl: wdata[0]};
  assign unused_ctrl_bits = ^{wdata[DW-2:5], wdata[2]};

  ppi_ctrl #(.DW(DW), .SELW(SELW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (mode_we),
    .bsr_we  (bsr_we),
    .dir_d   (dir_d),
    .bsr_idx (bsr_idx),
    .bsr_val (bsr_val),
    .dir_q   (dir_q),
    .int_en  (int_en)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic port_we, port_bit_we;
    assign port_we     = wr_en && (addr == 2'(g));
    assign port_bit_we = (g == int'(ADDR_C)) ? bsr_we : 1'b0;
    ppi_latch #(.W(DW), .SELW(SELW)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mode_we),
      .we      (port_we),
      .d       (wdata),
      .bit_we  (port_bit_we),
      .bit_idx (bsr_idx),
      .bit_val (bsr_val),
      .q       (lat[g])
    );
  end

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pc_out = lat[2];
  assign pa_oe  = {DW{~dir_q.a}};
  assign pb_oe  = {DW{~dir_q.b}};
  assign pc_oe  = {{H{~dir_q.cu}}, {H{~dir_q.cl}}};

  ppi_rdmux #(.DW(DW)) u_rdmux (
    .rd_en (cs & rd),
    .addr  (addr),
    .dir   (dir_q),
    .la    (lat[0]),
    .lb    (lat[1]),
    .lc    (lat[2]),
    .pa    (pa_in),
    .pb    (pb_in),
    .pc    (pc_in),
    .rdata (rdata)
  );
endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk #(
  parameter int DW = 8,
  localparam int SELW = $clog2(DW),
  localparam int H = DW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pb_oe,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] pc_oe,
  input logic [DW-1:0] int_en
);
  logic ctrl_w;
  assign ctrl_w = cs && wr && (addr == 2'd3);

  AST_MODE_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && wdata[DW-1] |=> (pa_oe == {DW{~$past(wdata[4])}}) && (pb_oe == {DW{~$past(wdata[1])}})
      && (pc_oe == {{H{~$past(wdata[3])}}, {H{~$past(wdata[0])}}})); // R2

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && wdata[DW-1] |=> (pa_out == '0) && (pb_out == '0) && (pc_out == '0) && (int_en == '0)); // R3

  AST_PORT_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cs && wr && (addr == 2'd0) |=> pa_out == $past(wdata)); // R4

  AST_NO_CS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(int_en)); // R4

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cs && rd && (addr == 2'd3) |-> rdata == '0); // R6

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == '0); // R6

  AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && !wdata[DW-1] |=> ($countones(pc_out ^ $past(pc_out)) <= 1)
      && (pc_out[$past(wdata[SELW:1])] == $past(wdata[0]))); // R7

  AST_BSR_INTE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && !wdata[DW-1] |=> (int_en[$past(wdata[SELW:1])] == $past(wdata[0]))
      && ($countones(int_en ^ $past(int_en)) <= 1)); // R8
endmodule

bind ppi_port ppi_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe),
  .int_en(int_en)
);

// File: tb/tb_ppi_port.sv
module tb_ppi_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cs = 0, rd = 0, wr = 0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [DW-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [DW-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe, int_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppi_port #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .int_en(int_en)
  );

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [DW-1:0] d, logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  // scenario: reset state
  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1", "pa_oe", pa_oe, 8'h00);
    check("R1", "pb_oe", pb_oe, 8'h00);
    check("R1", "pc_oe", pc_oe, 8'h00);
    check("R1", "pc_out", pc_out, 8'h00);
    check("R1", "int_en", int_en, 8'h00);
    pa_in = 8'h3C;
    bus_read(2'd0, v);
    check("R1", "read A live pins after reset", v, 8'h3C);
  endtask

  // scenario: every direction configuration
  task automatic t_modes();
    for (int i = 0; i < 16; i++) begin
      logic a, cu, b, cl;
      logic [DW-1:0] w;
      a = i[3]; cu = i[2]; b = i[1]; cl = i[0];
      w = 8'h80 | {3'b000, a, cu, 1'b0, b, cl};
      if (i % 2 == 1) w = w | 8'h64;  // bits 6,5,2 must not matter
      bus_write(2'd3, w);
      check("R2", $sformatf("pa_oe cfg %0d", i), pa_oe, {DW{~a}});
      check("R2", $sformatf("pb_oe cfg %0d", i), pb_oe, {DW{~b}});
      check("R2", $sformatf("pc_oe cfg %0d", i), pc_oe, {{4{~cu}}, {4{~cl}}});
    end
  endtask

  // scenario: write and read back with all outputs
  task automatic t_port_rw();
    logic [DW-1:0] v;
    bus_write(2'd3, 8'h80);
    pa_in = 8'hFF; pb_in = 8'hFF; pc_in = 8'hFF;
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h96);
    check("R4", "pa_out", pa_out, 8'h5A);
    check("R4", "pb_out", pb_out, 8'hC3);
    check("R4", "pc_out", pc_out, 8'h96);
    bus_read(2'd0, v); check("R5", "read A output latch", v, 8'h5A);
    bus_read(2'd1, v); check("R5", "read B output latch", v, 8'hC3);
    bus_read(2'd2, v); check("R5", "read C output latch", v, 8'h96);
    bus_write(2'd0, 8'h11, 1'b0);
    check("R4", "write without cs ignored", pa_out, 8'h5A);
  endtask

  // scenario: mixed directions, nibble-wise C read
  task automatic t_mixed();
    logic [DW-1:0] v;
    bus_write(2'd3, 8'h98);  // A in, Cu in, B out, Cl out
    bus_write(2'd1, 8'hE7);
    bus_write(2'd2, 8'hA5);
    pa_in = 8'h4B; pb_in = 8'h00; pc_in = 8'h3C;
    bus_read(2'd0, v); check("R5", "A input live", v, 8'h4B);
    bus_read(2'd1, v); check("R5", "B output latch", v, 8'hE7);
    bus_read(2'd2, v); check("R5", "C nibble mix", v, 8'h35);
    pc_in = 8'h9C;
    bus_read(2'd2, v); check("R5", "C upper follows pins", v, 8'h95);
  endtask

  // scenario: bit set/reset on port C and flags
  task automatic t_bsr();
    logic [DW-1:0] v;
    bus_write(2'd3, 8'h80);
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h7B);  // set bit 5, bits 6..4 junk
    check("R7", "set bit5 with junk high bits", pc_out, 8'h20);
    check("R8", "flag5 set", int_en, 8'h20);
    bus_write(2'd3, 8'h0A);
    check("R7", "clear bit5", pc_out, 8'h00);
    check("R8", "flag5 clear", int_en, 8'h00);
    v = '0;
    for (int k = 0; k < DW; k++) begin
      bus_write(2'd3, 8'((k << 1) | 1));
      v[k] = 1'b1;
      check("R7", $sformatf("walk set %0d", k), pc_out, v);
      check("R8", $sformatf("flag walk set %0d", k), int_en, v);
    end
    for (int k = 0; k < DW; k++) begin
      bus_write(2'd3, 8'(k << 1));
      v[k] = 1'b0;
      check("R7", $sformatf("walk clear %0d", k), pc_out, v);
      check("R8", $sformatf("flag walk clear %0d", k), int_en, v);
    end
  endtask

  // scenario: mode write clears everything
  task automatic t_mode_clear();
    bus_write(2'd0, 8'hAA);
    bus_write(2'd1, 8'h55);
    bus_write(2'd2, 8'hF0);
    bus_write(2'd3, 8'h07);  // set bit 3 and flag 3
    check("R8", "flag3 before mode", int_en, 8'h08);
    bus_write(2'd3, 8'h80);
    check("R3", "pa_out cleared", pa_out, 8'h00);
    check("R3", "pb_out cleared", pb_out, 8'h00);
    check("R3", "pc_out cleared", pc_out, 8'h00);
    check("R3", "int_en cleared", int_en, 8'h00);
  endtask

  // scenario: control read and idle bus
  task automatic t_ctrl_read();
    logic [DW-1:0] v;
    bus_write(2'd0, 8'h77);
    bus_read(2'd3, v);
    check("R6", "control read", v, 8'h00);
    @(negedge clk);
    cs = 1'b1; rd = 1'b0; addr = 2'd0;
    #1 check("R6", "rd low gives zero", rdata, 8'h00);
    cs = 1'b0; rd = 1'b1;
    #1 check("R6", "cs low gives zero", rdata, 8'h00);
    rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_port_rw();
    t_mixed();
    t_bsr();
    t_mode_clear();
    t_ctrl_read();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule